// File: doc/BRIEF.md
# SAR Converter Phase Sequencer

This block is the device-side control core of a serial successive-approximation converter. It moves through four phases: waiting, sampling, converting and napping. It raises a busy indication for the length of each conversion. The host's start strobe reaches the sequencer only through a qualifier that is transparent while chip select is low and holds its last value while chip select is high. A conversion begins on a falling edge of that qualified start, but only while the sequencer is sampling.

Sampling begins whenever start is high and chip select is low. This applies in the wait and nap phases and also in the last cycle of a conversion, so a host that keeps chip select low gets back-to-back conversions with no idle cycle. The block also watches the host's chip select, frame and serial clock lines. Switching on those lines inside protected windows is noise that degrades accuracy, and a read that begins too close to the end of a conversion can lose data. Both conditions raise sticky flags that a synchronous clear removes. All host lines pass through a two-stage synchroniser before any logic uses them. The conversion length and every window width are parameters counted in internal clock cycles.

Top module: `sar_phase_seq`

## Requirements
- R1: While reset is applied and until the first cycle after its release, the phase output is 2'b00 (wait), busy is low and both violation flags are low.
- R2: The phase output uses this encoding: 2'b00 wait, 2'b01 sample, 2'b10 convert, 2'b11 nap. Start transitions made while chip select is high have no effect on the phase, because the qualified start keeps its last value. If chip select is low with start low, the sequencer stays in wait.
- R3: From wait or nap, the sequencer enters sample when the synchronised start is high and the synchronised chip select is low. It leaves sample for convert only on a falling edge of the qualified start. Convert is entered from no other phase.
- R4: Convert lasts exactly CONV_CYCLES clock cycles, and busy is high in exactly those cycles.
- R5: In the last convert cycle, the next phase is chosen as follows. If start is high and chip select is low, it is sample with no intervening cycle. Otherwise it is nap when the nap enable is high, and wait when it is low.
- R6: A level change on chip select, frame or serial clock raises the quiet flag in any of these cases: it falls in the cycle of a conversion-starting edge, it falls within the QUIET_PRE cycles before that edge, or it falls within the QUIET_POST cycles after that edge. Activity elsewhere in a conversion leaves the flag low.
- R7: A level change on chip select, frame or serial clock during the final QUIET_END cycles of a conversion raises the quiet flag.
- R8: A read start raises the read flag when it falls in the final RD_SETUP convert cycles or in the RD_HOLD cycles after busy falls. A read start is either a falling edge of chip select or a rising edge of frame.
- R9: Both flags stay set until the clear input is sampled high. Clear overrides a new violation in the same cycle.
- R10: Every host line passes through two synchroniser stages before use. The sequencer reacts to a host change on the third or fourth rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Host conversion-start strobe (asynchronous) |
| cs_n_i | input | 1 | Host chip select, active low (asynchronous) |
| frame_i | input | 1 | Host frame signal; a rising edge starts a read (asynchronous) |
| sclk_i | input | 1 | Host serial clock, monitored for activity (asynchronous) |
| nap_en_i | input | 1 | Selects nap instead of wait after a conversion that is not chained |
| viol_clr_i | input | 1 | Synchronous clear of both violation flags |
| busy_o | output | 1 | High during the convert phase |
| phase_o | output | 2 | Current phase: 00 wait, 01 sample, 10 convert, 11 nap |
| quiet_viol_o | output | 1 | Sticky flag for activity in a quiet window |
| read_viol_o | output | 1 | Sticky flag for a read start near the busy falling edge |

## Verification
The hardest cases to reach from the ports are edges that must land on a specific cycle relative to internal events. One is a serial clock toggle that lands one or two cycles before the qualified start falls. Another is a chip select or frame edge that lands in the last two convert cycles or just after busy drops. The synchroniser delays each host change by two or three cycles. The stimulus therefore counts negative edges from the moment busy is seen to rise, and places each toggle that many cycles ahead of the target window. A behavioural model, with its own delay queues and integer counters, is compared against all four outputs on every cycle.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    PH_WAIT   = 2'b00,
    PH_SAMPLE = 2'b01,
    PH_CONV   = 2'b10,
    PH_NAP    = 2'b11
  } phase_e;
endpackage

// File: rtl/sps_sync.sv
// Two-stage synchroniser per line plus one history stage for edge detection.
module sps_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_line
      logic [2:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {3{RST_VAL[i]}};
        else        stage_q <= {stage_q[1:0], async_i[i]};
      end
      assign sync_o[i] = stage_q[1];
      assign prev_o[i] = stage_q[2];
    end
  endgenerate
endmodule

// File: rtl/sps_phase_fsm.sv
// Start qualifier and phase state machine with conversion counter.
module sps_phase_fsm
  import sps_pkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_s,
  input  logic             cs_n_s,
  input  logic             nap_en_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             conv_start_o,
  output logic             conv_done_o
);
  logic             qual_q, qual_d, qual_en;
  logic             qual_d1_q;
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_ok, qual_fall;

  // qualifier is transparent only while chip select is low
  assign qual_en   = ~cs_n_s;
  assign qual_d    = qual_en ? start_s : qual_q;
  assign qual_fall = qual_d1_q & ~qual_q;
  assign start_ok  = start_s & ~cs_n_s;

  assign conv_start_o = (phase_q == PH_SAMPLE) && qual_fall;
  assign conv_done_o  = (phase_q == PH_CONV) && (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_WAIT, PH_NAP: begin
        if (start_ok) phase_d = PH_SAMPLE;
      end
      PH_SAMPLE: begin
        if (qual_fall) begin
          phase_d = PH_CONV;
          cnt_d   = CNT_W'(CONV_CYCLES - 1);
        end
      end
      PH_CONV: begin
        if (cnt_q == '0) begin
          if (start_ok)      phase_d = PH_SAMPLE;
          else if (nap_en_i) phase_d = PH_NAP;
          else               phase_d = PH_WAIT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q    <= 1'b0;
      qual_d1_q <= 1'b0;
      phase_q   <= PH_WAIT;
      cnt_q     <= '0;
    end else begin
      qual_q    <= qual_d;
      qual_d1_q <= qual_q;
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sps_window_mon.sv
// Quiet-window and read-window monitors with sticky flags.
module sps_window_mon #(
  parameter int CNT_W      = 5,
  parameter int QUIET_PRE  = 2,
  parameter int QUIET_POST = 2,
  parameter int QUIET_END  = 3,
  parameter int RD_SETUP   = 2,
  parameter int RD_HOLD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             rd_start_i,
  input  logic             conv_start_i,
  input  logic             in_conv_i,
  input  logic             conv_done_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             quiet_viol_o,
  output logic             read_viol_o
);
  localparam int AGE_MAX = QUIET_PRE + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int POST_W  = $clog2(QUIET_POST + 2);
  localparam int HOLD_W  = $clog2(RD_HOLD + 2);

  logic [AGE_W-1:0]  age_q, age_d;
  logic [POST_W-1:0] post_q, post_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              quiet_q, quiet_d, read_q, read_d;
  logic              pre_hit, post_hit, end_hit, rd_hit;
  logic [31:0]       cnt_wide;

  assign cnt_wide = 32'(cnt_i);

  always_comb begin
    pre_hit  = conv_start_i && (act_i || (age_q <= AGE_W'(QUIET_PRE)));
    post_hit = (post_q != '0) && act_i;
    end_hit  = in_conv_i && (cnt_wide < QUIET_END) && act_i;
    rd_hit   = rd_start_i &&
               ((in_conv_i && (cnt_wide < RD_SETUP)) || (hold_q != '0));

    if (act_i)                           age_d = AGE_W'(1);
    else if (age_q == AGE_W'(AGE_MAX))   age_d = age_q;
    else                                 age_d = age_q + 1'b1;

    if (conv_start_i)        post_d = POST_W'(QUIET_POST);
    else if (post_q != '0)   post_d = post_q - 1'b1;
    else                     post_d = post_q;

    if (conv_done_i)         hold_d = HOLD_W'(RD_HOLD);
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
    else                     hold_d = hold_q;

    if (clr_i) begin
      quiet_d = 1'b0;
      read_d  = 1'b0;
    end else begin
      quiet_d = quiet_q | pre_hit | post_hit | end_hit;
      read_d  = read_q | rd_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q   <= AGE_W'(AGE_MAX);
      post_q  <= '0;
      hold_q  <= '0;
      quiet_q <= 1'b0;
      read_q  <= 1'b0;
    end else begin
      age_q   <= age_d;
      post_q  <= post_d;
      hold_q  <= hold_d;
      quiet_q <= quiet_d;
      read_q  <= read_d;
    end
  end

  assign quiet_viol_o = quiet_q;
  assign read_viol_o  = read_q;
endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
  import sps_pkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int QUIET_PRE   = 2,
  parameter int QUIET_POST  = 2,
  parameter int QUIET_END   = 3,
  parameter int RD_SETUP    = 2,
  parameter int RD_HOLD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cs_n_i,
  input  logic       frame_i,
  input  logic       sclk_i,
  input  logic       nap_en_i,
  input  logic       viol_clr_i,
  output logic       busy_o,
  output logic [1:0] phase_o,
  output logic       quiet_viol_o,
  output logic       read_viol_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int LINES = 4;
  // line order: [3] sclk, [2] frame, [1] cs_n, [0] start
  localparam logic [LINES-1:0] LINE_RST = 4'b0010;

  logic [1:0]       rst_sh_q;
  logic             rst_int_n;
  logic [LINES-1:0] raw, s_line, p_line;
  logic             act, rd_start;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             conv_start, conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  assign raw = {sclk_i, frame_i, cs_n_i, start_i};

  sps_sync #(.W(LINES), .RST_VAL(LINE_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i(raw),
    .sync_o (s_line),
    .prev_o (p_line)
  );

  assign act      = |(s_line[3:1] ^ p_line[3:1]);
  assign rd_start = (p_line[1] & ~s_line[1]) | (~p_line[2] & s_line[2]);

  sps_phase_fsm #(.CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_s     (s_line[0]),
    .cs_n_s      (s_line[1]),
    .nap_en_i    (nap_en_i),
    .phase_o     (phase),
    .cnt_o       (cnt),
    .conv_start_o(conv_start),
    .conv_done_o (conv_done)
  );

  sps_window_mon #(
    .CNT_W(CNT_W), .QUIET_PRE(QUIET_PRE), .QUIET_POST(QUIET_POST),
    .QUIET_END(QUIET_END), .RD_SETUP(RD_SETUP), .RD_HOLD(RD_HOLD)
  ) u_mon (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .act_i       (act),
    .rd_start_i  (rd_start),
    .conv_start_i(conv_start),
    .in_conv_i   (phase == PH_CONV),
    .conv_done_i (conv_done),
    .cnt_i       (cnt),
    .clr_i       (viol_clr_i),
    .quiet_viol_o(quiet_viol_o),
    .read_viol_o (read_viol_o)
  );

  assign phase_o = phase;
  assign busy_o  = (phase == PH_CONV);
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int CONV_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic [1:0] phase_o,
  input logic       nap_en_i,
  input logic       viol_clr_i,
  input logic       quiet_viol_o,
  input logic       read_viol_o
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1;
    else             busy_run_q <= '0;
  end

  AST_CONV_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b10 && $past(phase_o) != 2'b10) |-> $past(phase_o) == 2'b01); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run_q == CONV_CYCLES); // R4
  AST_NAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_o) == 2'b10 && phase_o == 2'b11) |-> $past(nap_en_i)); // R5
  AST_QUIET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(quiet_viol_o) && !$past(viol_clr_i)) |-> quiet_viol_o); // R9
  AST_READ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(read_viol_o) && !$past(viol_clr_i)) |-> read_viol_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(viol_clr_i) |-> (!quiet_viol_o && !read_viol_o)); // R9
endmodule

bind sar_phase_seq sps_checker #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .phase_o     (phase_o),
  .nap_en_i    (nap_en_i),
  .viol_clr_i  (viol_clr_i),
  .quiet_viol_o(quiet_viol_o),
  .read_viol_o (read_viol_o)
);

// File: tb/sar_phase_seq_test.sv
`timescale 1ns/1ps
module sar_phase_seq_test;
  localparam int CONV = 16, QPRE = 2, QPOST = 2, QEND = 3, RSU = 2, RHD = 2;

  logic clk, rst_n, start, cs_n, frame, sclk, nap_en, clr;
  logic busy; logic [1:0] phase; logic quiet, rdv;
  int errors = 0, checks = 0, cycles = 0;

  sar_phase_seq #(.CONV_CYCLES(CONV), .QUIET_PRE(QPRE), .QUIET_POST(QPOST),
    .QUIET_END(QEND), .RD_SETUP(RSU), .RD_HOLD(RHD)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cs_n_i(cs_n), .frame_i(frame),
    .sclk_i(sclk), .nap_en_i(nap_en), .viol_clr_i(clr), .busy_o(busy),
    .phase_o(phase), .quiet_viol_o(quiet), .read_viol_o(rdv));

  initial clk = 0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_rel;
  bit st_q[$], cs_q[$], fr_q[$], sk_q[$]; // [0]=newest .. [2]=history
  bit m_q, m_qd; int m_ph, m_cnt, m_age, m_post, m_hold; bit m_qv, m_rv;

  task automatic m_reset();
    m_rel = 0; st_q = '{0,0,0}; cs_q = '{1,1,1}; fr_q = '{0,0,0}; sk_q = '{0,0,0};
    m_q = 0; m_qd = 0; m_ph = 0; m_cnt = 0; m_age = QPRE + 1; m_post = 0; m_hold = 0;
    m_qv = 0; m_rv = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else if (m_rel < 2) m_rel++;
    else begin
      bit act, qfall, go, rds, cst, inc, done, h1, h2, h3, hr;
      int nph;
      act   = (cs_q[1] != cs_q[2]) || (fr_q[1] != fr_q[2]) || (sk_q[1] != sk_q[2]);
      qfall = m_qd && !m_q;
      go    = st_q[1] && !cs_q[1];
      rds   = (cs_q[2] && !cs_q[1]) || (!fr_q[2] && fr_q[1]);
      inc   = (m_ph == 2);
      cst   = (m_ph == 1) && qfall;
      done  = inc && m_cnt == 0;
      h1 = cst && (act || m_age <= QPRE);
      h2 = (m_post > 0) && act;
      h3 = inc && (m_cnt < QEND) && act;
      hr = rds && ((inc && m_cnt < RSU) || m_hold > 0);
      if (clr) begin m_qv = 0; m_rv = 0; end
      else begin m_qv = m_qv | h1 | h2 | h3; m_rv = m_rv | hr; end
      m_age  = act ? 1 : ((m_age > QPRE) ? QPRE + 1 : m_age + 1);
      m_post = cst ? QPOST : ((m_post > 0) ? m_post - 1 : 0);
      m_hold = done ? RHD : ((m_hold > 0) ? m_hold - 1 : 0);
      nph = m_ph;
      if ((m_ph == 0 || m_ph == 3) && go) nph = 1;
      else if (cst) begin nph = 2; m_cnt = CONV - 1; end
      else if (done) nph = go ? 1 : (nap_en ? 3 : 0);
      else if (inc) m_cnt--;
      m_ph = nph;
      m_qd = m_q;
      if (!cs_q[1]) m_q = st_q[1];
      st_q.push_front(start); void'(st_q.pop_back());
      cs_q.push_front(cs_n);  void'(cs_q.pop_back());
      fr_q.push_front(frame); void'(fr_q.pop_back());
      sk_q.push_front(sclk);  void'(sk_q.pop_back());
    end
  end

  // every-cycle comparison against the model (R2 phase, R4 busy, R6/R7 quiet, R8 read)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (phase != 2'(m_ph) || busy != (m_ph == 2) || quiet != m_qv || rdv != m_rv) begin
        errors++;
        $display("FAIL model R2/R4/R6/R8 cyc %0d: phase=%0d busy=%0d quiet=%0d read=%0d exp phase=%0d busy=%0d quiet=%0d read=%0d",
                 cycles, phase, busy, quiet, rdv, m_ph, m_ph == 2, m_qv, m_rv);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_busy(input bit v);
    for (int i = 0; i < 100 && busy != v; i++) step(1);
  endtask

  task automatic toggle_sclk(input int n);
    for (int i = 0; i < n; i++) begin sclk = ~sclk; step(1); end
  endtask

  task automatic pulse_clr();
    clr = 1; step(1); clr = 0; step(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; start = 0; cs_n = 1; frame = 0; sclk = 0; nap_en = 0; clr = 0;
    step(3);
    check("R1 phase in reset", phase, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1; step(4);
    check("R1 phase after release", phase, 0);
    check("R1 flags after release", {quiet, rdv}, 0);

    // R2: start strobes with chip select high are ignored
    for (int i = 0; i < 3; i++) begin start = 1; step(2); start = 0; step(2); end
    step(5);
    check("R2 start ignored with cs high", phase, 0);
    cs_n = 0; step(8);
    check("R2 cs low start low stays wait", phase, 0);

    // R3/R10: sampling then conversion
    start = 1; step(6);
    check("R3 wait->sample", phase, 1);
    start = 0;
    wait_busy(1);
    n = 0;
    while (busy && n < 100) begin n++; step(1); end
    check("R4 busy cycles", n, CONV);
    check("R5 no chain -> wait", phase, 0);
    check("R6 quiet clean conversion", quiet, 0);
    check("R8 read clean conversion", rdv, 0);

    // R5 nap path and R3 nap->sample
    nap_en = 1; start = 1; step(6); start = 0;
    wait_busy(1); wait_busy(0);
    check("R5 nap after conversion", phase, 3);
    start = 1; step(6);
    check("R3 nap->sample", phase, 1);

    // R5 back-to-back chaining
    start = 0; wait_busy(1); start = 1; wait_busy(0);
    check("R5 chained sample", phase, 1);
    // R6 activity mid-conversion is not a violation
    start = 0; wait_busy(1); step(3); toggle_sclk(4);
    wait_busy(0); step(2);
    check("R6 mid-conversion activity ignored", quiet, 0);

    // R7 activity just before busy falls
    nap_en = 0; start = 1; step(6); start = 0;
    wait_busy(1); step(10); toggle_sclk(4);
    wait_busy(0); step(3);
    check("R7 end-window activity", quiet, 1);
    step(5);
    check("R9 quiet sticky", quiet, 1);
    pulse_clr();
    check("R9 quiet cleared", quiet, 0);

    // R6 activity right before the qualified start falls
    start = 1; step(6); sclk = ~sclk; start = 0;
    wait_busy(1); wait_busy(0); step(2);
    check("R6 pre-window activity", quiet, 1);
    pulse_clr();
    // R6 activity right after the qualified start falls
    start = 1; step(6); start = 0; step(3); sclk = ~sclk;
    wait_busy(1); wait_busy(0); step(2);
    check("R6 post-window activity", quiet, 1);
    pulse_clr();

    // R8 chip-select-initiated read near busy fall
    start = 1; step(6); start = 0;
    wait_busy(1); step(4); cs_n = 1; step(8); cs_n = 0;
    wait_busy(0); step(3);
    check("R8 cs read in setup window", rdv, 1);
    pulse_clr();
    check("R9 read cleared", rdv, 0);

    // R8 frame-initiated read just after busy fall
    start = 1; step(6); start = 0;
    wait_busy(1); step(14); frame = 1;
    wait_busy(0); step(4);
    check("R8 frame read in hold window", rdv, 1);
    frame = 0; step(3);
    pulse_clr();
    step(5);
    check("R9 all clear at end", {quiet, rdv}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule